// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a 32-pin general-purpose I/O controller. It sits on a simple synchronous register bus with an address, a write enable, write data and a combinational read data path. Software sets the direction, the open-drain selection and the output value of each pin in registers. The block presents output-enable, output-value and open-drain signals to pad drivers that sit outside it. The level of each input pin is brought into the clock domain through a synchronizer, and software can read it back through the data register.

Each pin has an edge detector. A detected edge sets a sticky bit in an event register. Software clears that bit by writing a 1 to it. A per-pin control bit chooses between two modes: both edges raise the event, or only a falling edge raises it. A mask register selects which pending events can drive the single interrupt request output.

Pins are numbered from the most significant bit: pin n uses bit 31−n of every register and every pad vector.

Top module: `gpio_edge_unit`

## Requirements
- R1: After reset, every register reads zero, no event is pending, `irqOut` is low and `padOe`, `padOut` and `padOd` are zero. A read from an offset with no register behind it (0x18, 0x1C or any unaligned offset) returns zero, and a write to such an offset changes nothing.
- R2: Pin n maps to bit 31−n. A direction bit of 1 makes the pin an output, so `padOe` equals the direction register (offset 0x00).
- R3: The open-drain register (0x04), data register (0x08), mask register (0x10) and control register (0x14) hold the word last written to them. Direction (0x00) also reads back the word last written to it. `padOut` equals the data register and `padOd` equals the open-drain register.
- R4: A read of offset 0x08 returns the synchronized pad level for pins whose direction bit is 0, and the last written output value for pins whose direction bit is 1. A pad change becomes visible in that read after two rising clock edges.
- R5: A value written to the data register reaches `padOut` whether or not the pin is an output. When the direction is later switched to output, `padOut` for that pin does not change.
- R6: With control bit 0, both a rising and a falling synchronized edge set the pin's event bit (offset 0x0C). With control bit 1, only a falling edge sets it, and a rising edge leaves it unchanged.
- R7: A write to offset 0x0C clears exactly the event bits that are 1 in the written word. Writing 0xFFFFFFFF clears every pending event. Event bits never clear in any other way.
- R8: If an edge and a write-1-to-clear hit the same event bit in the same cycle, the bit stays set.
- R9: `irqOut` is high exactly when the bitwise AND of the event register and the mask register is nonzero.
- R10: An event bit and `irqOut` rise on the third rising clock edge after the pad changes: two synchronizer stages, then the edge comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte offset of the register |
| busWe | input | 1 | Write enable, sampled at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOe | output | 32 | Output enable per pin |
| padOut | output | 32 | Output value per pin |
| padOd | output | 32 | Open-drain select per pin |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench targets the case where a pad edge and a write-1-to-clear land on the same event bit in the same cycle. A design where the clear wins would drop that event. It checks that a rising edge on a falling-only pin stays silent; a design that ignored the mode would raise spurious events. It also checks that partial clears leave the other bits pending; a design that cleared the whole register would lose those events. Reads of the data register are checked on mixed-direction words, against the three-edge event latency, and against the bit reversal of pin numbers. Errors in any of these show up as wrong readback values or a misplaced `padOe` bit. A seeded random phase then interleaves register writes, pad changes and clears, and compares every result with a reference model.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int REG_W = 32;

  localparam int OFS_DIR  = 'h00;
  localparam int OFS_OD   = 'h04;
  localparam int OFS_DATA = 'h08;
  localparam int OFS_EVT  = 'h0C;
  localparam int OFS_MASK = 'h10;
  localparam int OFS_CTRL = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIR, SEL_OD, SEL_DATA, SEL_EVT, SEL_MASK, SEL_CTRL
  } rdSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrOd;
    logic wrData;
    logic evtClr;
    logic wrMask;
    logic wrCtrl;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output wrStrobe_t         strobe,
  output rdSel_e            rdSel
);
  logic [$bits(wrStrobe_t)-1:0] strobeVec;

  // Offset decode; anything unmatched selects nothing.
  always_comb begin
    rdSel = SEL_NONE;
    case (busAddr)
      ADDR_W'(OFS_DIR):  rdSel = SEL_DIR;
      ADDR_W'(OFS_OD):   rdSel = SEL_OD;
      ADDR_W'(OFS_DATA): rdSel = SEL_DATA;
      ADDR_W'(OFS_EVT):  rdSel = SEL_EVT;
      ADDR_W'(OFS_MASK): rdSel = SEL_MASK;
      ADDR_W'(OFS_CTRL): rdSel = SEL_CTRL;
      default:           rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.wrDir  = busWe && (rdSel == SEL_DIR);
    strobe.wrOd   = busWe && (rdSel == SEL_OD);
    strobe.wrData = busWe && (rdSel == SEL_DATA);
    strobe.evtClr = busWe && (rdSel == SEL_EVT);
    strobe.wrMask = busWe && (rdSel == SEL_MASK);
    strobe.wrCtrl = busWe && (rdSel == SEL_CTRL);
  end

  assign strobeVec = strobe;

  // R3: one bus write touches at most one register
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeVec));
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  input  rdSel_e           rdSel,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] padIn,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] padOe,
  output logic [NPINS-1:0] padOut,
  output logic [NPINS-1:0] padOd,
  output logic             irqOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] dirQ, odQ, dataQ, evtQ, maskQ, ctrlQ;
  logic [NPINS-1:0] syncQ [SYNC_STAGES];
  logic [NPINS-1:0] syncCur, prevQ, newEdge, clrMask, dataView;

  // Input synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign syncCur = syncQ[LAST];

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      odQ   <= '0;
      dataQ <= '0;
      maskQ <= '0;
      ctrlQ <= '0;
    end else begin
      if (strobe.wrDir)  dirQ  <= wdata;
      if (strobe.wrOd)   odQ   <= wdata;
      if (strobe.wrData) dataQ <= wdata;
      if (strobe.wrMask) maskQ <= wdata;
      if (strobe.wrCtrl) ctrlQ <= wdata;
    end
  end

  // Edge detection: falling always counts, rising only in both-edge mode
  assign newEdge = (prevQ & ~syncCur) | (~prevQ & syncCur & ~ctrlQ);
  assign clrMask = strobe.evtClr ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      evtQ  <= '0;
    end else begin
      prevQ <= syncCur;
      evtQ  <= (evtQ & ~clrMask) | newEdge;  // a new edge beats a clear
    end
  end

  assign irqOut   = |(evtQ & maskQ);
  assign padOe    = dirQ;
  assign padOut   = dataQ;
  assign padOd    = odQ;
  assign dataView = (syncCur & ~dirQ) | (dataQ & dirQ);

  always_comb begin
    case (rdSel)
      SEL_DIR:  rdata = dirQ;
      SEL_OD:   rdata = odQ;
      SEL_DATA: rdata = dataView;
      SEL_EVT:  rdata = evtQ;
      SEL_MASK: rdata = maskQ;
      SEL_CTRL: rdata = ctrlQ;
      default:  rdata = '0;
    endcase
  end

  // R7: without a clear strobe no pending event is lost
  assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.evtClr |=> ((evtQ & $past(evtQ)) == $past(evtQ)));

  // R8: an edge seen during a clear still leaves its bit set
  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evtClr |=> ((evtQ & $past(newEdge)) == $past(newEdge)));

  // R6: a falling-only pin never gains an event while its sample is high
  assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|ctrlQ) |=> ((evtQ & ~$past(evtQ) & $past(ctrlQ) & $past(syncCur)) == '0));

  // R5: the output value moves only on a data write
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrData |=> $stable(padOut));
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOd,
  output logic              irqOut
);
  wrStrobe_t strobe;
  rdSel_e    rdSel;

  gpio_edge_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .strobe(strobe), .rdSel(rdSel)
  );

  gpio_edge_dp #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wdata(busWdata), .padIn(padIn), .rdata(busRdata),
    .padOe(padOe), .padOut(padOut), .padOd(padOd), .irqOut(irqOut)
  );
endmodule

// File: tb/gpio_edge_unit_bench.sv
module gpio_edge_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, padOe, padOut, padOd;
  logic [31:0] padIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mDir = '0, mOd = '0, mData = '0, mEvt = '0, mMask = '0, mCtrl = '0, mPad = '0;

  always #10 clk = ~clk;

  gpio_edge_unit u_gpio_edge_unit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padOd(padOd), .irqOut(irqOut)
  );

  function automatic logic [31:0] pinBit(int n);
    return 32'h8000_0000 >> n;
  endfunction

  function automatic logic [31:0] edgesOf(logic [31:0] was, logic [31:0] now, logic [31:0] ctl);
    return (was & ~now) | (~was & now & ~ctl);
  endfunction

  function automatic logic [31:0] dataExp();
    return (mPad & ~mDir) | (mData & mDir);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rdChk(logic [4:0] a, logic [31:0] exp, string req);
    busAddr = a;
    #1;
    chk(req, busRdata, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    case (a)
      5'h00: mDir = d;
      5'h04: mOd = d;
      5'h08: mData = d;
      5'h0C: mEvt = mEvt & ~d;
      5'h10: mMask = d;
      5'h14: mCtrl = d;
      default: ;
    endcase
  endtask

  task automatic padSet(logic [31:0] v);
    @(negedge clk);
    mEvt = mEvt | edgesOf(mPad, v, mCtrl);
    mPad = v; padIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    rdChk(5'h00, mDir, {tag, " R2 dir"});
    rdChk(5'h04, mOd, {tag, " R3 od"});
    rdChk(5'h08, dataExp(), {tag, " R4 data"});
    rdChk(5'h0C, mEvt, {tag, " R6 evt"});
    rdChk(5'h10, mMask, {tag, " R3 mask"});
    rdChk(5'h14, mCtrl, {tag, " R3 ctrl"});
    chk({tag, " R9 irq"}, 32'(irqOut), 32'(|(mEvt & mMask)));
    chk({tag, " R2 padOe"}, padOe, mDir);
    chk({tag, " R3 padOut"}, padOut, mData);
    chk({tag, " R3 padOd"}, padOd, mOd);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state and unmapped offsets
    checkAll("R1 reset");
    rdChk(5'h18, 32'h0, "R1 unmapped 0x18");
    rdChk(5'h1C, 32'h0, "R1 unmapped 0x1C");
    wr(5'h02, 32'hFFFF_FFFF);
    rdChk(5'h02, 32'h0, "R1 unaligned read");
    checkAll("R1 unaligned write ignored");

    // R2: pin 0 is bit 31
    wr(5'h00, pinBit(0));
    chk("R2 pin0 oe", padOe, 32'h8000_0000);
    padSet(pinBit(31));
    rdChk(5'h08, 32'h0000_0001, "R2 pin31 input level");
    checkAll("R2");

    // R5: preload output value before switching direction
    wr(5'h08, 32'h0000_FF00);
    chk("R5 preload padOut", padOut, 32'h0000_FF00);
    chk("R5 preload oe off", padOe & 32'h0000_FF00, 32'h0);
    wr(5'h00, mDir | 32'h0000_FF00);
    chk("R5 oe on, value held", padOut, 32'h0000_FF00);
    rdChk(5'h08, dataExp(), "R4 mixed read");
    checkAll("R5");

    // R6: both-edge mode then falling-only mode
    wr(5'h0C, 32'hFFFF_FFFF);
    rdChk(5'h0C, 32'h0, "R7 clear all");
    padSet(mPad | pinBit(4));
    rdChk(5'h0C, pinBit(4), "R6 rising, both-edge");
    wr(5'h0C, pinBit(4));
    wr(5'h14, pinBit(4));
    padSet(mPad & ~pinBit(4));
    rdChk(5'h0C, pinBit(4), "R6 falling, falling-only");
    wr(5'h0C, pinBit(4));
    padSet(mPad | pinBit(4));
    rdChk(5'h0C, 32'h0, "R6 rising ignored, falling-only");
    wr(5'h14, 32'h0);

    // R7: partial clear
    padSet(mPad ^ 32'h0F00_00F0);
    wr(5'h0C, 32'h0300_0030);
    rdChk(5'h0C, 32'h0C00_00C0 | (mEvt & ~32'h0F00_00F0), "R7 partial clear");
    checkAll("R7");

    // R9: mask gates irq
    wr(5'h10, 32'h0);
    chk("R9 masked irq low", 32'(irqOut), 32'h0);
    wr(5'h10, 32'h0400_0000);
    chk("R9 unmasked irq high", 32'(irqOut), 32'h1);
    wr(5'h0C, 32'h0400_0000);
    chk("R9 irq low after clear", 32'(irqOut), 32'(|(mEvt & mMask)));

    // R10 and R4: latency of pad changes
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0);
    @(negedge clk);
    padIn = mPad ^ pinBit(9);
    @(negedge clk);
    rdChk(5'h08, mPad, "R4 one edge: old level");
    @(negedge clk);
    rdChk(5'h08, mPad ^ pinBit(9), "R4 two edges: new level");
    rdChk(5'h0C, 32'h0, "R10 two edges: no event");
    chk("R10 two edges: irq low", 32'(irqOut), 32'h0);
    @(negedge clk);
    rdChk(5'h0C, pinBit(9), "R10 three edges: event");
    chk("R10 three edges: irq high", 32'(irqOut), 32'h1);
    mEvt = pinBit(9);
    mPad = mPad ^ pinBit(9);

    // R8: edge and clear in the same cycle on a pending bit
    @(negedge clk);
    padIn = mPad ^ pinBit(9);
    @(negedge clk);
    @(negedge clk);
    busAddr = 5'h0C; busWe = 1'b1; busWdata = pinBit(9);
    @(negedge clk);
    busWe = 1'b0;
    mPad = mPad ^ pinBit(9);
    repeat (2) @(negedge clk);
    rdChk(5'h0C, pinBit(9), "R8 edge beats clear");
    checkAll("R8");

    // Random phase
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: begin
          logic [4:0] a;
          a = 5'(($urandom % 6) * 4);
          if (a == 5'h0C) a = 5'h14;
          wr(a, $urandom);
        end
        1, 2: padSet(mPad ^ ($urandom & $urandom));
        3: wr(5'h0C, $urandom);
        4: wr(5'h0C, 32'hFFFF_FFFF);
        default: wr(5'(5'h18 + 4 * ($urandom % 2)), $urandom);
      endcase
      checkAll("random");
    end

    finishRun();
  end
endmodule